// File: doc/BRIEF.md
# Multi-Channel Signal-Detect and Squelch Controller

This block watches twelve receive lanes, each of which delivers a raw level-detect flag that an analog comparator with hysteresis has already produced. Every lane flag passes through its own qualification filter. The filter accepts a new level only after the raw flag has held that level for a fixed number of timer ticks. The rising direction and the falling direction each have their own tick count. Any return of the raw flag to the accepted level before the count expires throws the partial count away. Short glitches therefore never reach the outputs.

The qualified lane flags feed two outputs. The first is a module-level signal-detect output. It goes high only when every lane is qualified healthy, and it drops when any single lane is qualified lost. The second is a per-lane output mode that the data path uses to choose, for each lane, between passing data, squelching the lane, or holding its output at a constant high level.

Three active-high enables adjust these outputs. One enable forces signal detect high. One enable turns squelching on or off. One enable, the receiver output enable, forces every lane high and takes priority over squelching. The enables are registered. Their registers reset to 1, so an enable that is left undriven reads as active.

Top module: `sdq_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sd_o` is 0 and every lane mode is SQUELCH (2'b01). This holds whatever levels the enable inputs carry during reset, because the enable registers reset to 1.
- R2: The timer tick fires once every TICK_DIV clocks. A lane's qualified flag rises only after its raw flag has been high on ASSERT_TICKS ticks in a row. It falls only after its raw flag has been low on DEASSERT_TICKS ticks in a row. With the defaults, the first edge of `sd_o` after a clean change of the lane flags lies between (N-1)*TICK_DIV+1 and N*TICK_DIV clocks, where N is the tick count for that direction.
- R3: If a raw lane flag returns to its qualified level before the count expires, the count restarts. Repeated drops that are each shorter than the deassert window never lower `sd_o`.
- R4: With the signal-detect enable high, `sd_o` is 1 exactly when all twelve qualified lane flags are 1.
- R5: With the signal-detect enable high, `sd_o` is 0 whenever any one qualified lane flag is 0.
- R6: With the signal-detect enable low, `sd_o` is 1 regardless of lane state.
- R7: Lane i's mode is the 2-bit field at bits [2i+1:2i] of `lane_mode_o`. With the squelch enable high, a lane whose own qualified flag is 0 has mode SQUELCH (2'b01), and a lane whose flag is 1 has mode PASS (2'b00). With the squelch enable low, every lane has mode PASS.
- R8: With the receiver output enable low, every lane has mode FORCE_HIGH (2'b10). This overrides squelching.
- R9: Each enable input is sampled into a register. A change on an enable input shows at the outputs one clock after the edge that samples it.

Top module port order follows the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_det_i | input | NUM_CH (12) | Raw per-lane level-detect flags, 1 = adequate level |
| sd_en_i | input | 1 | Signal-detect enable; low forces `sd_o` high |
| sq_en_i | input | 1 | Squelch enable |
| rx_en_i | input | 1 | Receiver output enable; low forces all lanes high |
| sd_o | output | 1 | Filtered module-level signal detect |
| lane_mode_o | output | 2*NUM_CH (24) | Per-lane mode: 00 PASS, 01 SQUELCH, 10 FORCE_HIGH |

## Verification
A wrong tick phase or a wrong qualification count moves the `sd_o` edge outside its window of one tick width. It also moves the edge at which a lane enters or leaves SQUELCH. Both show within roughly ASSERT_TICKS*TICK_DIV clocks of a lane change. A filter that fails to restart its count lets a burst of short drops lower `sd_o` on the second burst. A wrong enable reset value or a wrong enable priority shows on the very first cycles after reset, or one clock after an enable toggles, as a wrong lane code or a wrong `sd_o` level.

// File: rtl/sdq_pkg.sv
// Shared types for the signal-detect and squelch controller.
// Assumes the lane mode is packed into two bits per lane.
package sdq_pkg;

    typedef enum logic [1:0] {
        LANE_PASS     = 2'b00,
        LANE_SQUELCH  = 2'b01,
        LANE_FORCE_HI = 2'b10
    } lane_mode_e;

endpackage

// File: rtl/sdq_tick_gen.sv
// Timebase: emits a one-cycle tick every TICK_DIV clocks, counted from reset.
// Assumes TICK_DIV >= 1; TICK_DIV == 1 makes the tick permanently high.
module sdq_tick_gen #(
    parameter int TICK_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (TICK_DIV == 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int TW = $clog2(TICK_DIV);
            localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);
            logic [TW-1:0] cnt_q;

            // Purpose: free-running divider that wraps at LAST.
            always_ff @(posedge clk) begin
                if (!rst_n)            cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == LAST);

            // R2: ticks are isolated pulses
            a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/sdq_lane_qual.sv
// One lane's qualification filter. The accepted level follows the raw flag
// only after the raw flag has disagreed with it for RISE_TICKS ticks
// (going high) or FALL_TICKS ticks (going low). Agreement clears the count.
// Assumes raw_i is already synchronous to clk.
module sdq_lane_qual #(
    parameter int RISE_TICKS = 17,
    parameter int FALL_TICKS = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic det_o
);

    localparam int MAXT = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_TICKS - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_TICKS - 1);

    logic          det_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Purpose: select the window that applies to the pending direction.
    always_comb last = raw_i ? RISE_LAST : FALL_LAST;

    // Purpose: count disagreeing ticks and flip the accepted level at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= 1'b0;
            cnt_q <= '0;
        end else if (raw_i == det_q) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == last) begin
                det_q <= raw_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign det_o = det_q;

    // R2: the accepted level moves only on a tick
    a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(det_q));

    // R3: agreement with the raw flag leaves the accepted level alone
    a_r3_agree_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == det_q) |=> $stable(det_q));

    // R2: the count never runs past the longer window
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAXT));

endmodule

// File: rtl/sdq_lane_mode.sv
// Per-lane output mode: forced high beats squelch, squelch applies to a lane
// whose own qualified flag is low. Purely combinational.
module sdq_lane_mode
    import sdq_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  logic [NUM_CH-1:0]   det_i,
    input  logic                sq_en_i,
    input  logic                rx_en_i,
    output logic [2*NUM_CH-1:0] mode_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_lane
            lane_mode_e m;

            // Purpose: apply the fixed enable priority to this lane.
            always_comb begin
                if (!rx_en_i)                 m = LANE_FORCE_HI;
                else if (sq_en_i && !det_i[g]) m = LANE_SQUELCH;
                else                          m = LANE_PASS;
            end

            assign mode_o[2*g +: 2] = m;

            // R7: the unused code never appears
            always_comb begin
                a_r7_legal_code: assert (m != lane_mode_e'(2'b11));
            end
        end
    endgenerate

endmodule

// File: rtl/sdq_ctrl.sv
// Top: twelve-lane signal-detect aggregation and squelch control.
// Enables are registered with a reset value of 1 so an undriven enable
// reads as active. Assumes all inputs are synchronous to clk.
module sdq_ctrl
    import sdq_pkg::*;
#(
    parameter int NUM_CH       = 12,
    parameter int TICK_DIV     = 5,
    parameter int ASSERT_TICKS = 17,
    parameter int DEASSERT_TICKS = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   lane_det_i,
    input  logic                sd_en_i,
    input  logic                sq_en_i,
    input  logic                rx_en_i,
    output logic                sd_o,
    output logic [2*NUM_CH-1:0] lane_mode_o
);

    logic              tick;
    logic [NUM_CH-1:0] det;
    logic              sd_en_q, sq_en_q, rx_en_q;

    // Purpose: sample the enables; reset makes them active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_en_q <= 1'b1;
            sq_en_q <= 1'b1;
            rx_en_q <= 1'b1;
        end else begin
            sd_en_q <= sd_en_i;
            sq_en_q <= sq_en_i;
            rx_en_q <= rx_en_i;
        end
    end

    sdq_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_qual
            sdq_lane_qual #(
                .RISE_TICKS(ASSERT_TICKS),
                .FALL_TICKS(DEASSERT_TICKS)
            ) qual_i (
                .clk   (clk),
                .rst_n (rst_n),
                .tick_i(tick),
                .raw_i (lane_det_i[g]),
                .det_o (det[g])
            );
        end
    endgenerate

    // Purpose: all lanes healthy raises detect; the enable can force it high.
    always_comb sd_o = !sd_en_q || (&det);

    sdq_lane_mode #(.NUM_CH(NUM_CH)) mode_i (
        .det_i  (det),
        .sq_en_i(sq_en_q),
        .rx_en_i(rx_en_q),
        .mode_o (lane_mode_o)
    );

    // Purpose: flag any lane currently squelched, for the checks below.
    logic any_sq;
    always_comb begin
        any_sq = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (lane_mode_o[2*i +: 2] == LANE_SQUELCH) any_sq = 1'b1;
    end

    // R4: detect high means no lane is being squelched
    a_r4_sd_no_squelch: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_o && sd_en_q) |-> !any_sq);

    // R5: a squelched lane keeps detect low while detect is enabled
    a_r5_squelch_drops_sd: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_en_q && any_sq) |-> !sd_o);

    // R8: forced-high lanes never carry squelch
    a_r8_force_no_squelch: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_q |-> !any_sq);

endmodule

// File: tb/sdq_ctrl_tb_top.sv
module sdq_ctrl_tb_top;

    localparam int NCH = 12;
    localparam int TD  = 5;
    localparam int AT  = 17;
    localparam int DT  = 19;
    localparam logic [NCH-1:0] ALL1 = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   lane_det = '0;
    logic             sd_en = 1'b0, sq_en = 1'b0, rx_en = 1'b0;
    logic             sd_o;
    logic [2*NCH-1:0] lane_mode;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    sdq_ctrl #(.NUM_CH(NCH), .TICK_DIV(TD), .ASSERT_TICKS(AT), .DEASSERT_TICKS(DT)) dut_i (
        .clk(clk), .rst_n(rst_n), .lane_det_i(lane_det),
        .sd_en_i(sd_en), .sq_en_i(sq_en), .rx_en_i(rx_en),
        .sd_o(sd_o), .lane_mode_o(lane_mode)
    );

    // Reference model written from the requirements
    logic           m_sd_en, m_sq_en, m_rx_en;
    logic [NCH-1:0] m_q;
    int             m_cnt [NCH];
    int             m_t;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sd_en <= 1; m_sq_en <= 1; m_rx_en <= 1;
            m_q <= '0; m_t <= 0;
            for (int i = 0; i < NCH; i++) m_cnt[i] <= 0;
        end else begin
            m_sd_en <= sd_en; m_sq_en <= sq_en; m_rx_en <= rx_en;
            m_t <= (m_t == TD - 1) ? 0 : m_t + 1;
            for (int i = 0; i < NCH; i++) begin
                if (lane_det[i] == m_q[i]) m_cnt[i] <= 0;
                else if (m_t == TD - 1) begin
                    if (m_cnt[i] + 1 >= (lane_det[i] ? AT : DT)) begin
                        m_q[i] <= lane_det[i];
                        m_cnt[i] <= 0;
                    end else m_cnt[i] <= m_cnt[i] + 1;
                end
            end
        end
    end

    function automatic logic exp_sd(logic en, logic [NCH-1:0] q);
        return !en || (&q);
    endfunction

    function automatic logic [1:0] exp_lane(logic q, logic sq, logic rx);
        if (!rx) return 2'b10;
        if (sq && !q) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk(!m_sd_en ? "R6 sd forced" : ((&m_q) ? "R4 sd all-good" : "R5 sd lane-lost"),
                32'(sd_o), 32'(exp_sd(m_sd_en, m_q)));
            for (int i = 0; i < NCH; i++)
                chk(!m_rx_en ? "R8 lane forced" : "R7 lane mode",
                    32'(lane_mode[2*i +: 2]), 32'(exp_lane(m_q[i], m_sq_en, m_rx_en)));
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int k;
        void'($urandom(32'd4711));
        // R1: reset values with enable inputs held low
        wait_cyc(3);
        chk("R1 sd in reset", 32'(sd_o), 32'd0);
        for (int i = 0; i < NCH; i++) chk("R1 lane in reset", 32'(lane_mode[2*i +: 2]), 32'd1);
        sd_en = 1; sq_en = 1; rx_en = 1;
        rst_n = 1;
        @(negedge clk);
        chk("R1 sd after reset", 32'(sd_o), 32'd0);
        chk("R1 lane0 after reset", 32'(lane_mode[1:0]), 32'd1);
        cmp_on = 1;
        wait_cyc(20);

        // R2: assert timing window
        lane_det = ALL1;
        k = 0;
        do begin @(negedge clk); k++; end while (!sd_o && k < 1000);
        chk("R2 assert lo-bound", 32'(k >= (AT-1)*TD+1), 32'd1);
        chk("R2 assert hi-bound", 32'(k <= AT*TD), 32'd1);
        wait_cyc(10);

        // R3: two short drops on lane 3 never lower detect
        for (int r = 0; r < 2; r++) begin
            lane_det[3] = 1'b0;
            for (int c = 0; c < (DT-2)*TD; c++) begin
                @(negedge clk);
                chk("R3 glitch hold", 32'(sd_o), 32'd1);
            end
            lane_det[3] = 1'b1;
            @(negedge clk);
        end

        // R2: deassert timing window
        lane_det[5] = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (sd_o && k < 1000);
        chk("R2 deassert lo-bound", 32'(k >= (DT-1)*TD+1), 32'd1);
        chk("R2 deassert hi-bound", 32'(k <= DT*TD), 32'd1);
        chk("R7 lane5 squelched", 32'(lane_mode[11:10]), 32'd1);
        chk("R7 lane4 passes", 32'(lane_mode[9:8]), 32'd0);

        // R9: enables act one clock after sampling
        sq_en = 0;
        @(negedge clk);
        chk("R9 squelch off", 32'(lane_mode[11:10]), 32'd0);
        sq_en = 1; sd_en = 0;
        @(negedge clk);
        chk("R6 sd forced high", 32'(sd_o), 32'd1);
        sd_en = 1; rx_en = 0;
        @(negedge clk);
        chk("R8 forced over squelch", 32'(lane_mode[11:10]), 32'd2);
        chk("R8 forced lane0", 32'(lane_mode[1:0]), 32'd2);
        rx_en = 1;
        wait_cyc(2);

        // Constrained random phases checked by the model
        for (int p = 0; p < 200; p++) begin
            int sel = $urandom % 4;
            case (sel)
                0: lane_det = ALL1;
                1: lane_det = ALL1 & ~(NCH'(1) << ($urandom % NCH));
                2: lane_det = NCH'($urandom);
                default: lane_det = '0;
            endcase
            sd_en = ($urandom % 8) != 0;
            sq_en = ($urandom % 8) != 0;
            rx_en = ($urandom % 8) != 0;
            wait_cyc(1 + $urandom % 250);
        end

        cmp_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule